// File: doc/BRIEF.md
# SPI Target with Automatic Clock Polarity Detection

This block is the target (slave) end of a four-wire SPI link that needs no mode setting. On the cycle it sees chip select go active, it records the level of the serial clock. The master must park the clock at its idle level before it selects the target, so that level gives the clock polarity of the transaction. An idle-low clock means mode 0 and an idle-high clock means mode 3.

Both modes sample on rising edges and shift out on falling edges, so the target needs only one datapath. The mode changes just one thing: whether the first transmit bit is on the line from select time (mode 0) or from the first falling edge (mode 3).

The serial clock, the data input and the select line are each brought into the fast system clock through a synchronizer chain. All edges are found from successive synchronized samples. On the parallel side there are three things:
- a transmit buffer, written with a one-cycle load strobe;
- a received byte, with a one-cycle valid pulse;
- the detected mode.

Frames are 8 bits, most significant bit first. Bytes run back to back for as long as select is held.

Top module: `spi_autopol_slave`

## Requirements
- R1: While reset is asserted and after it is released with select inactive, `rx_valid` is 0, `spi_miso_oe` is 0 and `mode_o` is 2'b00.
- R2: When select asserts, the synchronized clock level is latched. A low level shows `mode_o` = 2'b00 and a high level shows 2'b11, within a few system cycles. The value is held unchanged until the next select assertion.
- R3: The data input is sampled on each rising serial clock edge, MSB first. After every 8th rising edge of a transaction, `rx_data` holds the byte and `rx_valid` pulses high for exactly one cycle.
- R4: The MISO data changes only on falling serial clock edges, MSB first. In mode 0, bit 7 of the loaded byte is on `spi_miso` from select assertion onward.
- R5: In mode 3, the first falling edge of a transaction presents bit 7 without shifting. Each later falling edge advances by one bit.
- R6: A `tx_load` pulse stores `tx_data` in the transmit buffer. The buffer is copied into the shifter when select asserts, and on the first falling edge after each complete byte, so that bytes follow one another with no gap.
- R7: `spi_miso_oe` is 1 only while select is active. Whenever it is 0, `spi_miso` is released to high impedance.
- R8: If select deasserts before a byte completes, no `rx_valid` pulse is produced for that byte. The bit count restarts at zero for the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, high impedance when not selected |
| spi_miso_oe | output | 1 | High while the target drives `spi_miso` |
| tx_data | input | WORD_BITS | Next byte to transmit |
| tx_load | input | 1 | One-cycle strobe that writes `tx_data` into the transmit buffer |
| rx_data | output | WORD_BITS | Last complete received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_data` is updated |
| mode_o | output | 2 | Detected mode number: 2'b00 or 2'b11 |

## Verification
A wrong latched polarity shows on `mode_o` within a few cycles of select. It then shows again at the first transmit bit: mode 0 would present the MSB early, and mode 3 would lose a bit through an extra shift.

A bit counter that drifts or survives an aborted byte makes `rx_data` arrive misaligned by the next `rx_valid` pulse, at most 8 serial clocks later. A shifter that loads at the wrong boundary corrupts MISO on the very next sampled bit.

The sweeps send every byte value in each direction in both modes, so any single misaligned bit shows up as a mismatch.

// File: rtl/spi_ap_pkg.sv
package spi_ap_pkg;

   typedef enum logic [1:0] {
      SPI_MODE0 = 2'b00,
      SPI_MODE3 = 2'b11
   } spi_mode_e;

   // Mode number is (polarity << 1) | phase; both detected modes share
   // polarity and phase, so one latched level yields the whole number.
   function automatic spi_mode_e mode_from_level(input logic idle_level);
      return idle_level ? SPI_MODE3 : SPI_MODE0;
   endfunction

endpackage

// File: rtl/spi_ap_sync.sv
module spi_ap_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_ap_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_ap_frontend.sv
module spi_ap_frontend #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_pin,
   input  logic cs_n_pin,
   input  logic mosi_pin,
   output logic sclk_lvl,
   output logic mosi_lvl,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic cs_assert,
   output logic cs_idle
);

   localparam int N_SIG = 3;
   localparam logic [N_SIG-1:0] RST_VALS = 3'b010; // {mosi, cs_n, sclk}

   logic [N_SIG-1:0] raw_vec;
   logic [N_SIG-1:0] syn_vec;
   logic             sclk_prev;
   logic             cs_prev;

   assign raw_vec = {mosi_pin, cs_n_pin, sclk_pin};

   generate
      for (genvar i = 0; i < N_SIG; i++) begin : g_sync
         spi_ap_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(RST_VALS[i])
         ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_vec[i]),
            .q    (syn_vec[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         cs_prev   <= 1'b1;
      end else begin
         sclk_prev <= syn_vec[0];
         cs_prev   <= syn_vec[1];
      end
   end

   assign sclk_lvl  = syn_vec[0];
   assign cs_idle   = syn_vec[1];
   assign mosi_lvl  = syn_vec[2];
   assign sclk_rise = syn_vec[0] & ~sclk_prev;
   assign sclk_fall = ~syn_vec[0] & sclk_prev;
   assign cs_assert = cs_prev & ~syn_vec[1];

endmodule

// File: rtl/spi_ap_rx.sv
module spi_ap_rx #(
   parameter int WORD_BITS = 8,
   localparam int CNT_W = $clog2(WORD_BITS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 restart,
   input  logic                 accept,
   input  logic                 sclk_rise,
   input  logic                 mosi_lvl,
   output logic [WORD_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 at_boundary
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

   logic [CNT_W-1:0]     bit_cnt;
   logic [WORD_BITS-1:0] shreg;
   logic [WORD_BITS-1:0] shreg_nxt;

   assign shreg_nxt = {shreg[WORD_BITS-2:0], mosi_lvl};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (restart || !accept) begin
            bit_cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= shreg_nxt;
            if (bit_cnt == LAST_BIT) begin
               bit_cnt  <= '0;
               rx_data  <= shreg_nxt;
               rx_valid <= 1'b1;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign at_boundary = (bit_cnt == '0);

endmodule

// File: rtl/spi_ap_tx.sv
module spi_ap_tx #(
   parameter int WORD_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_load,
   input  logic [WORD_BITS-1:0] tx_data,
   input  logic                 restart,
   input  logic                 idle_high,
   input  logic                 accept,
   input  logic                 sclk_fall,
   input  logic                 at_boundary,
   output logic                 tx_bit
);

   logic [WORD_BITS-1:0] buf_q;
   logic [WORD_BITS-1:0] shreg;
   logic                 hold_first;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (tx_load) begin
         buf_q <= tx_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         hold_first <= 1'b0;
      end else if (restart) begin
         shreg      <= buf_q;
         hold_first <= idle_high;
      end else if (accept && sclk_fall) begin
         if (hold_first) begin
            hold_first <= 1'b0;
         end else if (at_boundary) begin
            shreg <= buf_q;
         end else begin
            shreg <= {shreg[WORD_BITS-2:0], 1'b0};
         end
      end
   end

   assign tx_bit = shreg[WORD_BITS-1];

endmodule

// File: rtl/spi_autopol_slave.sv
module spi_autopol_slave
   import spi_ap_pkg::*;
#(
   parameter int WORD_BITS   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 spi_sclk,
   input  logic                 spi_cs_n,
   input  logic                 spi_mosi,
   output logic                 spi_miso,
   output logic                 spi_miso_oe,
   input  logic [WORD_BITS-1:0] tx_data,
   input  logic                 tx_load,
   output logic [WORD_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic [1:0]           mode_o
);

   generate
      if (WORD_BITS < 2) begin : g_bad_word
         $error("spi_autopol_slave: WORD_BITS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_autopol_slave: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic      sclk_lvl;
   logic      mosi_lvl;
   logic      sclk_rise;
   logic      sclk_fall;
   logic      cs_assert;
   logic      cs_idle;
   logic      active;
   logic      accept;
   logic      at_boundary;
   logic      tx_bit;
   spi_mode_e mode_q;

   spi_ap_frontend #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_front (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_pin (spi_sclk),
      .cs_n_pin (spi_cs_n),
      .mosi_pin (spi_mosi),
      .sclk_lvl (sclk_lvl),
      .mosi_lvl (mosi_lvl),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .cs_assert(cs_assert),
      .cs_idle  (cs_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         mode_q <= SPI_MODE0;
      end else if (cs_idle) begin
         active <= 1'b0;
      end else if (cs_assert) begin
         active <= 1'b1;
         mode_q <= mode_from_level(sclk_lvl);
      end
   end

   assign accept = active & ~cs_idle;

   spi_ap_rx #(
      .WORD_BITS(WORD_BITS)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (cs_assert),
      .accept     (accept),
      .sclk_rise  (sclk_rise),
      .mosi_lvl   (mosi_lvl),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .at_boundary(at_boundary)
   );

   spi_ap_tx #(
      .WORD_BITS(WORD_BITS)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_load    (tx_load),
      .tx_data    (tx_data),
      .restart    (cs_assert),
      .idle_high  (sclk_lvl),
      .accept     (accept),
      .sclk_fall  (sclk_fall),
      .at_boundary(at_boundary),
      .tx_bit     (tx_bit)
   );

   assign spi_miso_oe = active;
   assign spi_miso    = active ? tx_bit : 1'bz;
   assign mode_o      = mode_q;

endmodule

// File: rtl/spi_autopol_slave_chk.sv
module spi_autopol_slave_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_idle,
   input logic       spi_miso_oe,
   input logic       rx_valid,
   input logic [1:0] mode_o
);

   // R2
   mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 2'b00) || (mode_o == 2'b11));

   // R2
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_miso_oe && $past(spi_miso_oe)) |-> $stable(mode_o));

   // R3
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R7
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> !spi_miso_oe);

   // R8
   no_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_idle |=> !rx_valid);

endmodule

bind spi_autopol_slave spi_autopol_slave_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cs_idle    (cs_idle),
   .spi_miso_oe(spi_miso_oe),
   .rx_valid   (rx_valid),
   .mode_o     (mode_o)
);

// File: tb/spi_autopol_slave_tb.sv
module spi_autopol_slave_tb;

   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sclk;
   logic       cs_n;
   logic       mosi;
   logic [7:0] tx_data;
   logic       tx_load;
   wire        miso;
   wire        miso_oe;
   wire  [7:0] rx_data;
   wire        rx_valid;
   wire  [1:0] mode;

   int checks = 0;
   int errors = 0;
   int rx_cnt = 0;
   logic [7:0] rx_log [0:1023];

   always #2 clk = ~clk;

   spi_autopol_slave u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sclk   (sclk),
      .spi_cs_n   (cs_n),
      .spi_mosi   (mosi),
      .spi_miso   (miso),
      .spi_miso_oe(miso_oe),
      .tx_data    (tx_data),
      .tx_load    (tx_load),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .mode_o     (mode)
   );

   always @(posedge clk) begin
      if (rst_n && rx_valid) begin
         rx_log[rx_cnt[9:0]] <= rx_data;
         rx_cnt <= rx_cnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] txv(input int k, input bit hi);
      return hi ? 8'(k * 29 + 101) : 8'(k * 7 + 3);
   endfunction

   function automatic logic [7:0] rxv(input int k, input bit hi);
      return hi ? 8'(k * 13 + 5) : 8'(k);
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load_tx(input logic [7:0] v);
      @(negedge clk);
      tx_data = v;
      tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   // abort_bits > 0: drop select after that many bits of the first byte
   task automatic xfer(input bit hi, input int nbytes, input int abort_bits);
      int  base;
      bit  stop;
      logic [7:0] tb_byte;
      logic [7:0] rb_byte;
      stop = 1'b0;
      sclk = hi;
      wait_clk(H);
      load_tx(txv(0, hi));
      base = rx_cnt;
      cs_n = 1'b0;
      wait_clk(H);
      chk("R2 detected mode", int'(mode), hi ? 3 : 0);
      chk("R7 output enabled while selected", int'(miso_oe), 1);
      for (int k = 0; k < nbytes && !stop; k++) begin
         tb_byte = txv(k, hi);
         rb_byte = rxv(k, hi);
         for (int b = 0; b < 8 && !stop; b++) begin
            if (abort_bits > 0 && (k * 8 + b) >= abort_bits) begin
               stop = 1'b1;
            end else begin
               if (hi) sclk = 1'b0;
               mosi = rb_byte[7 - b];
               wait_clk(H);
               if (hi) chk("R5 mode 3 MISO bit", int'(miso), int'(tb_byte[7 - b]));
               else    chk("R4 mode 0 MISO bit", int'(miso), int'(tb_byte[7 - b]));
               if (b == 0 && k + 1 < nbytes) load_tx(txv(k + 1, hi)); // R6
               sclk = 1'b1;
               wait_clk(H);
               if (!hi) sclk = 1'b0;
            end
         end
      end
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(H);
      chk("R7 output released after deselect", int'(miso_oe), 0);
      if (abort_bits > 0) begin
         chk("R8 no pulse for partial byte", rx_cnt - base, 0);
      end else begin
         chk("R3 received byte count", rx_cnt - base, nbytes);
         for (int k = 0; k < nbytes; k++) begin
            chk("R3 received byte value", int'(rx_log[(base + k) % 1024]), int'(rxv(k, hi)));
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n   = 1'b0;
      cs_n    = 1'b1;
      sclk    = 1'b0;
      mosi    = 1'b0;
      tx_data = '0;
      tx_load = 1'b0;
      wait_clk(5);
      chk("R1 reset rx_valid", int'(rx_valid), 0);
      chk("R1 reset oe", int'(miso_oe), 0);
      chk("R1 reset mode", int'(mode), 0);
      rst_n = 1'b1;
      wait_clk(5);
      chk("R1 idle oe", int'(miso_oe), 0);
      chk("R1 idle mode", int'(mode), 0);

      xfer(1'b0, 256, 0);   // every value both ways, mode 0
      xfer(1'b1, 256, 0);   // every value both ways, mode 3
      xfer(1'b0, 1, 5);     // R8 abort in mode 0
      xfer(1'b0, 3, 0);     // R8 fresh count afterwards
      xfer(1'b1, 1, 3);     // R8 abort in mode 3
      xfer(1'b1, 4, 0);
      xfer(1'b0, 2, 0);     // R2 switches back to mode 0

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule